// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave end of a serial memory reached over a four-wire SPI link. It samples the serial clock, the active-low select and the serial input into its own system clock through a synchronizer, and detects clock and select edges there. Everything else runs on that single clock. The first byte after select falls is decoded as a command. Memory commands then take a three-byte address, and data bytes stream to or from a small on-chip byte array. The address steps forward after every byte, so a burst runs for as long as select stays low.

An 8-bit status register holds a write-enable latch and a few configuration bits. Write and status-write commands only take effect while the latch is set. An unknown command locks the slave out until the next select falling edge. The serial output comes with a separate drive enable that an I/O cell at chip level uses as its tristate control.

The on-chip array is parameterised and small. The 19-bit location number is folded onto it modulo its depth.

Top module: `spimem_slave`

## Requirements
- R1: The first byte after a select falling edge is the command. The recognised codes are 0x06 (set write-enable latch), 0x04 (clear it), 0x05 (status read), 0x01 (status write), 0x03 (memory read) and 0x02 (memory write).
- R2: Command, address and data bytes all travel most significant bit first, on both the input and the output.
- R3: Read and write commands are followed by three address bytes. Only the low 19 bits of those 24 bits select a location; the upper five bits have no effect.
- R4: Both clock idle levels are accepted: low (mode 0) and high (mode 3). Input bits are taken on rising clock edges, starting with the first rising edge after select falls.
- R5: The serial output changes only on a falling clock edge. The drive enable is high only during the data phase of a memory read or a status read. The first output bit appears on the falling edge that follows the command's or address's last rising edge.
- R6: After an unrecognised command, all further input is ignored and the drive enable stays low until the next select falling edge.
- R7: The write-enable latch is status bit 1. It is set by 0x06 and cleared by 0x04. While it is clear, memory writes and status writes change nothing.
- R8: The write-enable latch clears when select rises at the end of any memory-write or status-write command.
- R9: The location number increments after every data byte of a read or write burst and wraps from 0x7FFFF to 0. The array entry used is the location number modulo the array depth.
- R10: Select rising at any point returns the slave to idle and drops the drive enable. A partly received byte is never written.
- R11: A status write updates status bits 7, 3 and 2 only. Bit 0 always reads 0. After reset the status reads 0x00.
- R12: After reset the drive enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low slave select |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Drive enable for so (high drives, low means high impedance) |

## Verification
Several properties are checked on every system cycle. The output bit may move only in a cycle that carries a detected falling clock edge. A select rise must leave the slave idle with its output undriven. The lockout must persist until select falls again. The status configuration may change only while the latch is set, the latch must be clear after a write command ends, and every array write must step the location by one modulo 2^19. The arithmetic content is shown only by the bench's scenarios. These cover a full-array burst written in one mode and read back in the other, the fold and wrap at the top location, address bits that are ignored, commands sent bit-reversed or unknown, and a write cut short mid-byte.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam int LOC_W = 19;

  localparam logic [7:0] CMD_LATCH_SET = 8'h06;
  localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;
  localparam logic [7:0] CMD_MEM_RD    = 8'h03;
  localparam logic [7:0] CMD_MEM_WR    = 8'h02;

  // status bits a status write may change
  localparam logic [7:0] STAT_WMASK = 8'h8C;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA,
    ST_STIN, ST_STOUT, ST_DONE, ST_LOCK
  } st_e;

  // shift one address byte in; keeping LOC_W bits drops the don't-care top
  function automatic logic [LOC_W-1:0] addr_shift(logic [LOC_W-1:0] a, logic [7:0] b);
    return {a[LOC_W-9:0], b};
  endfunction

  function automatic logic [LOC_W-1:0] addr_step(logic [LOC_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [7:0] stat_view(logic [7:0] cfg, logic latch);
    return (cfg & STAT_WMASK) | {6'b0, latch, 1'b0};
  endfunction

endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spimem_mem.sv
module spimem_mem #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk)
    if (we) cells[waddr] <= wdata;

  assign rdata = cells[raddr];
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int IDX_W = $clog2(MEM_DEPTH);

  // synchronised pins and edge events
  logic [2:0] pins_s;
  logic sck_s, csn_s, si_s, sck_d, csn_d;
  logic sck_rise_ev, sck_fall_ev, cs_fall_ev, cs_rise_ev;

  spimem_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, si}), .q(pins_s));

  assign {sck_s, csn_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
    end

  assign sck_rise_ev = sck_s & ~sck_d;
  assign sck_fall_ev = ~sck_s & sck_d;
  assign cs_fall_ev  = ~csn_s & csn_d;
  assign cs_rise_ev  = csn_s & ~csn_d;

  // transaction state
  st_e              state;
  logic [2:0]       bitcnt;
  logic [6:0]       shreg;
  logic [1:0]       abyte;
  logic [LOC_W-1:0] addr_q;
  logic [7:0]       tx_q;
  logic             so_q;
  logic [7:0]       sr_cfg;
  logic             wel, wr_cmd, is_read;

  logic             active, byte_done, mem_we, locked;
  logic [7:0]       rx_byte, rd_data;
  logic [LOC_W-1:0] addr_nx, rd_loc;

  assign active    = ~csn_s && state != ST_IDLE && state != ST_LOCK;
  assign rx_byte   = {shreg, si_s};
  assign byte_done = sck_rise_ev && active && bitcnt == 3'd7;
  assign addr_nx   = addr_shift(addr_q, rx_byte);
  assign rd_loc    = (state == ST_ADDR) ? addr_nx : addr_q;
  assign mem_we    = byte_done && state == ST_WDATA && wel;
  assign locked    = state == ST_LOCK;

  spimem_mem #(.DEPTH(MEM_DEPTH)) mem_i (
    .clk(clk), .we(mem_we), .waddr(addr_q[IDX_W-1:0]), .wdata(rx_byte),
    .raddr(rd_loc[IDX_W-1:0]), .rdata(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      abyte   <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      so_q    <= 1'b0;
      sr_cfg  <= '0;
      wel     <= 1'b0;
      wr_cmd  <= 1'b0;
      is_read <= 1'b0;
    end else if (cs_fall_ev) begin
      state  <= ST_CMD;
      bitcnt <= '0;
      abyte  <= '0;
      wr_cmd <= 1'b0;
    end else if (cs_rise_ev) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      if (wr_cmd) wel <= 1'b0;
    end else begin
      if (sck_rise_ev && active) begin
        bitcnt <= bitcnt + 3'd1;
        shreg  <= rx_byte[6:0];
      end
      if (byte_done) begin
        case (state)
          ST_CMD: begin
            case (rx_byte)
              CMD_LATCH_SET: begin wel <= 1'b1; state <= ST_DONE; end
              CMD_LATCH_CLR: begin wel <= 1'b0; state <= ST_DONE; end
              CMD_STAT_RD:   begin tx_q <= stat_view(sr_cfg, wel); state <= ST_STOUT; end
              CMD_STAT_WR:   begin wr_cmd <= 1'b1; state <= ST_STIN; end
              CMD_MEM_RD:    begin is_read <= 1'b1; state <= ST_ADDR; end
              CMD_MEM_WR:    begin is_read <= 1'b0; wr_cmd <= 1'b1; state <= ST_ADDR; end
              default:       state <= ST_LOCK;
            endcase
          end
          ST_ADDR: begin
            if (abyte == 2'd2) begin
              if (is_read) begin
                tx_q   <= rd_data;
                addr_q <= addr_step(addr_nx);
                state  <= ST_RDATA;
              end else begin
                addr_q <= addr_nx;
                state  <= ST_WDATA;
              end
            end else begin
              addr_q <= addr_nx;
              abyte  <= abyte + 2'd1;
            end
          end
          ST_WDATA: addr_q <= addr_step(addr_q);
          ST_RDATA: begin
            tx_q   <= rd_data;
            addr_q <= addr_step(addr_q);
          end
          ST_STIN: begin
            if (wel) sr_cfg <= rx_byte & STAT_WMASK;
            state <= ST_DONE;
          end
          ST_STOUT: tx_q <= stat_view(sr_cfg, wel);
          default: ;
        endcase
      end
      if (sck_fall_ev && so_oe) begin
        so_q <= tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign so_oe = ~csn_s && (state == ST_RDATA || state == ST_STOUT);
  assign so    = so_q;

endmodule

// File: rtl/spimem_chk.sv
module spimem_chk
  import spimem_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sck_fall_ev,
  input logic             cs_fall_ev,
  input logic             cs_rise_ev,
  input logic             so_q,
  input logic             so_oe,
  input logic             locked,
  input logic             wel,
  input logic             wr_cmd,
  input logic             mem_we,
  input logic [LOC_W-1:0] addr_q,
  input logic [7:0]       sr_cfg,
  input st_e              state
);
  // R5
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall_ev |=> $stable(so_q));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_ev |=> (state == ST_IDLE) && !so_oe);

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !cs_fall_ev |=> locked || state == ST_IDLE);

  // R7
  stat_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(sr_cfg));

  // R8
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_ev && wr_cmd |=> !wel);

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> addr_q == addr_step($past(addr_q)));
endmodule

bind spimem_slave spimem_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sck_fall_ev(sck_fall_ev), .cs_fall_ev(cs_fall_ev),
  .cs_rise_ev(cs_rise_ev), .so_q(so_q), .so_oe(so_oe), .locked(locked), .wel(wel),
  .wr_cmd(wr_cmd), .mem_we(mem_we), .addr_q(addr_q), .sr_cfg(sr_cfg), .state(state));

// File: tb/spimem_slave_tb.sv
module spimem_slave_tb_top;
  localparam int DEPTH = 64;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic mode3 = 1'b0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rb;
  logic oe_any;

  always #2.5 clk = ~clk;

  spimem_slave #(.MEM_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel();
    sck  = mode3;
    cs_n = 1'b0;
    oe_any = 1'b0;
    wait_half();
  endtask

  task automatic desel();
    wait_half();
    cs_n = 1'b1;
    sck  = mode3;
    wait_half();
    wait_half();
  endtask

  // shifts nbits of din out and gathers the bits seen on so before each rise
  task automatic xfer(input logic [7:0] din, input int nbits, output logic [7:0] dout);
    logic oe_b;
    dout = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (mode3) sck = 1'b0;
      si = din[7-i];
      wait_half();
      dout[7-i] = so;
      oe_b = so_oe;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      wait_half();
      oe_any = oe_any | so_oe;
      if (oe_b && so_oe) check("R5 so held through high phase", so, dout[7-i]);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel();
    xfer(op, 8, d);
    desel();
  endtask

  task automatic read_status(output logic [7:0] v);
    logic [7:0] d;
    sel();
    xfer(8'h05, 8, d);
    xfer(8'h00, 8, v);
    desel();
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], 8, d);
    xfer(a[15:8], 8, d);
    xfer(a[7:0], 8, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R12 drive enable low after reset", so_oe, 1'b0);
    read_status(rb);
    check("R11 status after reset", rb, 8'h00);

    cmd1(8'h06);
    read_status(rb);
    check("R1 R7 latch set", rb, 8'h02);
    cmd1(8'h04);
    read_status(rb);
    check("R7 latch cleared", rb, 8'h00);

    // 0x60 is 0x06 bit-reversed: LSB-first sending must not set the latch
    cmd1(8'h60);
    read_status(rb);
    check("R2 bit-reversed command ignored", rb, 8'h00);

    // full-array write in mode 0, junk in the upper five address bits
    cmd1(8'h06);
    sel();
    xfer(8'h02, 8, d);
    send_addr(24'hA8_0000);
    for (int i = 0; i < DEPTH; i++) begin
      xfer(pat(i), 8, d);
      model[i] = pat(i);
    end
    desel();
    read_status(rb);
    check("R8 latch cleared after write", rb, 8'h00);

    // burst read in mode 3, one byte past the array to show the fold
    mode3 = 1'b1;
    sel();
    xfer(8'h03, 8, d);
    send_addr(24'hF8_0000);
    for (int i = 0; i <= DEPTH; i++) begin
      xfer(8'h00, 8, rb);
      check("R3 R4 R9 burst read", rb, model[i % DEPTH]);
    end
    desel();

    // write across the top location, then read it back
    mode3 = 1'b0;
    cmd1(8'h06);
    sel();
    xfer(8'h02, 8, d);
    send_addr(24'h07_FFFF);
    xfer(8'h5A, 8, d);
    xfer(8'hC3, 8, d);
    desel();
    model[DEPTH-1] = 8'h5A;
    model[0] = 8'hC3;
    sel();
    xfer(8'h03, 8, d);
    send_addr(24'h07_FFFF);
    xfer(8'h00, 8, rb);
    check("R9 top location", rb, model[DEPTH-1]);
    xfer(8'h00, 8, rb);
    check("R9 wrap to zero", rb, model[0]);
    desel();

    // write with the latch clear
    sel();
    xfer(8'h02, 8, d);
    send_addr(24'h00_0005);
    xfer(8'hAA, 8, d);
    desel();
    sel();
    xfer(8'h03, 8, d);
    send_addr(24'h00_0005);
    xfer(8'h00, 8, rb);
    check("R7 write without latch", rb, model[5]);
    desel();

    // abort mid-byte
    cmd1(8'h06);
    sel();
    xfer(8'h02, 8, d);
    send_addr(24'h00_0006);
    xfer(8'h11, 8, d);
    xfer(8'hEE, 5, d);
    desel();
    model[6] = 8'h11;
    check("R10 drive enable after abort", so_oe, 1'b0);
    sel();
    xfer(8'h03, 8, d);
    send_addr(24'h00_0006);
    xfer(8'h00, 8, rb);
    check("R10 full byte written", rb, model[6]);
    xfer(8'h00, 8, rb);
    check("R10 partial byte dropped", rb, model[7]);
    desel();
    read_status(rb);
    check("R8 latch cleared after aborted write", rb, 8'h00);

    // unknown command lockout, mode 3
    mode3 = 1'b1;
    sel();
    xfer(8'hFF, 8, d);
    xfer(8'h06, 8, d);
    xfer(8'h05, 8, d);
    xfer(8'h00, 8, d);
    check("R6 no drive while locked", oe_any, 1'b0);
    desel();
    read_status(rb);
    check("R6 lockout swallowed latch set", rb, 8'h00);

    // status writes
    cmd1(8'h06);
    sel();
    xfer(8'h01, 8, d);
    xfer(8'hFF, 8, d);
    desel();
    read_status(rb);
    check("R11 R8 status write masked", rb, 8'h8C);
    cmd1(8'h01);
    sel();
    xfer(8'h01, 8, d);
    xfer(8'h00, 8, d);
    desel();
    read_status(rb);
    check("R7 status write without latch", rb, 8'h8C);
    cmd1(8'h06);
    sel();
    xfer(8'h05, 8, d);
    xfer(8'h00, 8, rb);
    check("R11 status with latch", rb, 8'h8E);
    xfer(8'h00, 8, rb);
    check("R1 status repeats", rb, 8'h8E);
    desel();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule